// File: doc/BRIEF.md
# Serial Byte Receiver with Sticky Error Status

This block recovers bytes from an asynchronous serial line. It waits on an idle-high line for a falling edge, then counts a programmed number of clock cycles. It checks that the line is still low before it treats the edge as the start of a frame. From that point it samples once per bit period. Eight data bits arrive least-significant first. An optional parity bit may follow, and then one stop bit. A finished byte moves into a holding buffer, and a one-cycle completion pulse reports the new byte.

Parity, framing and overrun errors are kept as sticky flags, and an error pulse goes out alongside the completion pulse of any frame that had a problem. Software clears the flags and frees the buffer in two steps: it reads the status, and after that it reads the data. Any other read order leaves both the flags and the full buffer in place, so the next frame is counted as an overrun and its byte is dropped.

Top module: `serial_rx_unit`

## Requirements
- R1: Frames are received only while both `power_en` and `rx_en` are high. With either one low, no `done_irq` pulse ever appears.
- R2: A falling edge counts as a start bit only if the synchronised line is still low when the counter reaches `divisor`. A low pulse of `divisor` cycles or fewer, followed by a high line, produces no frame.
- R3: One bit period is 2*(`divisor`+1) clock cycles. The eight data bits arrive least-significant first, and the completed byte appears on `rx_data`.
- R4: `parity_mode` selects the parity check: 0 means no parity bit, 1 means even, 2 means odd, and 3 means the parity bit must be 0. A mismatch sets `stat_flags[0]`, the frame still runs to its stop bit, and the byte is still buffered.
- R5: A stop bit sampled low sets `stat_flags[1]`. Only one stop bit is checked, and a second high stop bit causes no extra frame and no error.
- R6: `done_irq` is a one-cycle pulse for each completed frame. `err_irq` pulses in the same cycle when that frame had a parity, framing or overrun error.
- R7: A frame that completes while the buffer is still full sets `stat_flags[2]` and leaves `rx_data` unchanged.
- R8: A `rd_data` strobe that follows a `rd_stat` strobe clears all flags and empties the buffer. A `rd_data` strobe with no `rd_stat` before it changes neither.
- R9: Driving `power_en` low aborts any frame in progress and clears the flags and the buffer-full state.
- R10: After reset, `stat_flags`, `rx_data`, `done_irq` and `err_irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_en | input | 1 | Receiver power/enable; low clears state |
| rx_en | input | 1 | Receive enable, set after power_en |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| divisor | input | 8 | Half-bit count minus one |
| parity_mode | input | 2 | 0 none, 1 even, 2 odd, 3 zero |
| rd_stat | input | 1 | Status read strobe |
| rd_data | input | 1 | Data read strobe |
| stat_flags | output | 3 | {overrun, framing, parity} sticky flags |
| rx_data | output | 8 | Receive buffer contents |
| done_irq | output | 1 | Frame completion pulse |
| err_irq | output | 1 | Frame error pulse |

## Verification
A wrong bit counter or sample point shows up at the end of the frame in progress. It gives a shifted or corrupted byte on `rx_data`, a false framing flag, or a missing or extra `done_irq`. A bad read-order tracker or buffer-full state shows up one frame later, as an overrun flag and an `err_irq` that should not be there, or as a lost byte. Random bytes, divisors, parity modes, injected errors and read orders are compared against a bench model after every frame. This bounds the time to detect each fault to one or two frame times.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_ZERO = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_s = sync_q[STAGES-1];
  assign fall   = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              line_s,
  input  logic              fall,
  input  logic [DIV_W-1:0]  divisor,
  input  par_mode_e         par_mode,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_err,
  output logic              frm_err
);
  localparam int CNT_W = DIV_W + 1;
  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] shreg_q, shreg_n;
  logic              perr_q, perr_n;
  logic              ferr_q, ferr_n;
  logic              done_q, done_n;
  logic [CNT_W-1:0]  half_end, full_end;
  logic              par_bad;

  assign half_end = {1'b0, divisor};
  assign full_end = {divisor, 1'b1};

  always_comb begin
    unique case (par_mode)
      PAR_EVEN: par_bad = ^shreg_q ^ line_s;
      PAR_ODD:  par_bad = ~(^shreg_q ^ line_s);
      PAR_ZERO: par_bad = line_s;
      default:  par_bad = 1'b0;
    endcase
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q + 1'b1;
    idx_n   = idx_q;
    shreg_n = shreg_q;
    perr_n  = perr_q;
    ferr_n  = ferr_q;
    done_n  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_n = '0;
        if (fall) state_n = ST_START;
      end
      ST_START: begin
        if (cnt_q == half_end) begin
          cnt_n  = '0;
          idx_n  = '0;
          perr_n = 1'b0;
          state_n = line_s ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (cnt_q == full_end) begin
          cnt_n   = '0;
          shreg_n = {line_s, shreg_q[DATA_W-1:1]};
          idx_n   = idx_q + 1'b1;
          if (idx_q == IDX_W'(DATA_W - 1))
            state_n = (par_mode == PAR_NONE) ? ST_STOP : ST_PAR;
        end
      end
      ST_PAR: begin
        if (cnt_q == full_end) begin
          cnt_n   = '0;
          perr_n  = par_bad;
          state_n = ST_STOP;
        end
      end
      ST_STOP: begin
        if (cnt_q == full_end) begin
          cnt_n   = '0;
          ferr_n  = ~line_s;
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (!active) begin
      state_n = ST_IDLE;
      done_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      shreg_q <= shreg_n;
      perr_q  <= perr_n;
      ferr_q  <= ferr_n;
      done_q  <= done_n;
    end
  end

  assign done    = done_q;
  assign data    = shreg_q;
  assign par_err = perr_q;
  assign frm_err = ferr_q;
endmodule

// File: rtl/srx_status.sv
module srx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_en,
  input  logic              active,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              rd_stat,
  input  logic              rd_data,
  output logic [2:0]        flags,
  output logic [DATA_W-1:0] buf_data,
  output logic              done_irq,
  output logic              err_irq
);
  logic [2:0]        flags_q, flags_n;
  logic [DATA_W-1:0] buf_q, buf_n;
  logic              full_q, full_n;
  logic              seen_q, seen_n;
  logic              done_q, done_n;
  logic              err_q, err_n;
  logic              clr, complete, ovr, wr_en;

  always_comb begin
    clr      = rd_data & seen_q;
    complete = frame_done & active;
    wr_en    = complete & (~full_q | clr);
    ovr      = complete & full_q & ~clr;
    seen_n   = clr ? 1'b0 : (seen_q | rd_stat);
    full_n   = wr_en ? 1'b1 : (clr ? 1'b0 : full_q);
    buf_n    = wr_en ? frame_data : buf_q;
    flags_n  = (clr ? 3'b000 : flags_q) |
               {ovr, complete & frm_err, complete & par_err};
    done_n   = complete;
    err_n    = complete & (par_err | frm_err | ovr);
    if (!power_en) begin
      seen_n  = 1'b0;
      full_n  = 1'b0;
      flags_n = 3'b000;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      buf_q   <= '0;
      full_q  <= 1'b0;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      full_q  <= full_n;
      seen_q  <= seen_n;
      done_q  <= done_n;
      err_q   <= err_n;
      if (wr_en) buf_q <= buf_n;
    end
  end

  assign flags    = flags_q;
  assign buf_data = buf_q;
  assign done_irq = done_q;
  assign err_irq  = err_q;
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import srx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_en,
  input  logic              rx_en,
  input  logic              rx_line,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        parity_mode,
  input  logic              rd_stat,
  input  logic              rd_data,
  output logic [2:0]        stat_flags,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_irq,
  output logic              err_irq
);
  logic              line_s, fall, active;
  logic              f_done, f_perr, f_ferr;
  logic [DATA_W-1:0] f_data;

  assign active = power_en & rx_en;

  srx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .line_in(rx_line), .line_s(line_s), .fall(fall)
  );

  srx_framer #(.DIV_W(DIV_W), .DATA_W(DATA_W)) framer_i (
    .clk(clk), .rst_n(rst_n), .active(active), .line_s(line_s), .fall(fall),
    .divisor(divisor), .par_mode(par_mode_e'(parity_mode)),
    .done(f_done), .data(f_data), .par_err(f_perr), .frm_err(f_ferr)
  );

  srx_status #(.DATA_W(DATA_W)) status_i (
    .clk(clk), .rst_n(rst_n), .power_en(power_en), .active(active),
    .frame_done(f_done), .frame_data(f_data), .par_err(f_perr),
    .frm_err(f_ferr), .rd_stat(rd_stat), .rd_data(rd_data),
    .flags(stat_flags), .buf_data(rx_data), .done_irq(done_irq),
    .err_irq(err_irq)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              power_en,
  input logic              rx_en,
  input logic              rd_data,
  input logic [2:0]        stat_flags,
  input logic [DATA_W-1:0] rx_data,
  input logic              done_irq,
  input logic              err_irq
);
  // R1
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(power_en && rx_en) |=> !done_irq);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> done_irq);

  // R7
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_flags[2]) |-> $stable(rx_data));

  // R9
  power_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !power_en |=> (stat_flags == 3'b000));

  // R8
  flag_clear_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat_flags) & ~stat_flags)) |-> ($past(rd_data) || !$past(power_en)));
endmodule

bind serial_rx_unit srx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .power_en(power_en), .rx_en(rx_en),
  .rd_data(rd_data), .stat_flags(stat_flags), .rx_data(rx_data),
  .done_irq(done_irq), .err_irq(err_irq)
);

// File: tb/serial_rx_unit_tb_top.sv
`timescale 1ns/1ps
module serial_rx_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, power_en, rx_en, rx_line, rd_stat, rd_data;
  logic [7:0] divisor;
  logic [1:0] parity_mode;
  logic [2:0] stat_flags;
  logic [7:0] rx_data;
  logic       done_irq, err_irq;

  int n_checks = 0, n_fail = 0;
  int done_cnt = 0, err_cnt = 0, exp_done = 0, exp_err = 0;
  logic [7:0] exp_data;
  logic [2:0] exp_flags;
  bit exp_full, exp_seen, finished;

  always #5 clk = ~clk;

  serial_rx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .power_en(power_en), .rx_en(rx_en),
    .rx_line(rx_line), .divisor(divisor), .parity_mode(parity_mode),
    .rd_stat(rd_stat), .rd_data(rd_data), .stat_flags(stat_flags),
    .rx_data(rx_data), .done_irq(done_irq), .err_irq(err_irq)
  );

  always @(negedge clk) begin
    if (rst_n && done_irq) done_cnt++;
    if (rst_n && err_irq)  err_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit par_value(input logic [7:0] b, input logic [1:0] m);
    case (m)
      2'd1: return ^b;
      2'd2: return ~^b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic hold(input bit v, input int cycles);
    rx_line = v;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input int div, input logic [1:0] m,
                            input bit bad_par, input bit stop_v, input int nstop);
    int p;
    p = 2 * (div + 1);
    @(negedge clk);
    divisor = 8'(div);
    parity_mode = m;
    hold(1'b0, p);
    for (int i = 0; i < 8; i++) hold(b[i], p);
    if (m != 2'd0) hold(par_value(b, m) ^ bad_par, p);
    hold(stop_v, p);
    if (nstop == 2) hold(1'b1, p);
    hold(1'b1, p + 6);
  endtask

  task automatic model_frame(input logic [7:0] b, input logic [1:0] m,
                             input bit bad_par, input bit stop_v);
    bit pe, fe, oe;
    pe = (m != 2'd0) && bad_par;
    fe = !stop_v;
    oe = exp_full;
    if (!exp_full) begin
      exp_data = b;
      exp_full = 1'b1;
    end
    exp_flags |= {oe, fe, pe};
    exp_done++;
    if (pe || fe || oe) exp_err++;
  endtask

  task automatic strobe_stat();
    @(negedge clk); rd_stat = 1'b1;
    @(negedge clk); rd_stat = 1'b0;
    exp_seen = 1'b1;
  endtask

  task automatic strobe_data();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
    if (exp_seen) begin
      exp_flags = 3'b000;
      exp_full  = 1'b0;
      exp_seen  = 1'b0;
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " rx_data"}, rx_data, exp_data);
    chk({req, " stat_flags"}, stat_flags, exp_flags);
    chk({req, " done count"}, done_cnt, exp_done);
    chk({req, " err count"}, err_cnt, exp_err);
  endtask

  initial begin
    finished = 1'b0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17_0C3E));
    rst_n = 1'b0; power_en = 1'b0; rx_en = 1'b0; rx_line = 1'b1;
    rd_stat = 1'b0; rd_data = 1'b0; divisor = 8'd4; parity_mode = 2'd0;
    exp_data = 8'h00; exp_flags = 3'b000; exp_full = 1'b0; exp_seen = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 flags", stat_flags, 0);
    chk("R10 data", rx_data, 0);
    chk("R10 done", done_irq, 0);
    chk("R10 err", err_irq, 0);

    // R1: receive enable without power, then power without receive enable
    rx_en = 1'b1;
    send_frame(8'h3C, 4, 2'd0, 0, 1, 1);
    chk("R1 no frame without power", done_cnt, 0);
    rx_en = 1'b0; power_en = 1'b1;
    send_frame(8'hC3, 4, 2'd0, 0, 1, 1);
    chk("R1 no frame without rx_en", done_cnt, 0);
    rx_en = 1'b1;
    @(negedge clk);

    // R3 basic frame, LSB first
    send_frame(8'hA6, 4, 2'd0, 0, 1, 1);
    model_frame(8'hA6, 2'd0, 0, 1);
    check_all("R3");

    // R2 short low glitch rejected
    rx_line = 1'b0;
    repeat (5) @(negedge clk);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 glitch gives no frame", done_cnt, exp_done);

    // R7 overrun: buffer still full
    send_frame(8'h51, 5, 2'd1, 0, 1, 1);
    model_frame(8'h51, 2'd1, 0, 1);
    check_all("R7");

    // R8 data read without status read changes nothing
    strobe_data();
    check_all("R8 data-only read");
    strobe_stat();
    strobe_data();
    check_all("R8 ordered read");

    // R5 framing error, then R4 parity error, then R9 power drop
    send_frame(8'h0F, 3, 2'd2, 0, 0, 1);
    model_frame(8'h0F, 2'd2, 0, 0);
    check_all("R5");
    strobe_stat(); strobe_data();
    send_frame(8'h80, 3, 2'd3, 1, 1, 2);
    model_frame(8'h80, 2'd3, 1, 1);
    check_all("R4");
    @(negedge clk); power_en = 1'b0;
    @(negedge clk); @(negedge clk);
    exp_flags = 3'b000; exp_full = 1'b0; exp_seen = 1'b0;
    chk("R9 flags cleared", stat_flags, 0);
    power_en = 1'b1;
    send_frame(8'h5A, 2, 2'd0, 0, 1, 1);
    model_frame(8'h5A, 2'd0, 0, 1);
    check_all("R9 buffer free after power drop");

    // Random frames: R3 R4 R5 R6 R7 R8
    for (int k = 0; k < 40; k++) begin
      logic [7:0] b;
      logic [1:0] m;
      int div, rdp, ns;
      bit bp, sv;
      b   = 8'($urandom);
      m   = 2'($urandom);
      div = 2 + int'($urandom % 9);
      bp  = ($urandom % 5) == 0;
      sv  = ($urandom % 7) != 0;
      ns  = 1 + int'($urandom % 2);
      send_frame(b, div, m, bp, sv, ns);
      model_frame(b, m, bp, sv);
      check_all("R6 random");
      rdp = int'($urandom % 4);
      case (rdp)
        1: begin strobe_stat(); strobe_data(); end
        2: strobe_data();
        3: begin strobe_data(); strobe_stat(); end
        default: ;
      endcase
      chk("R8 random read flags", stat_flags, exp_flags);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule